// File: doc/BRIEF.md
# FP32 to BF16 Narrowing Converter

This block turns single-precision floating-point values into bfloat16 and places the results into a 128-bit destination vector. Every lane is rounded to nearest with ties to even. NaNs come out quiet. Infinities and signed zeros pass through unchanged.

A request carries a 128-bit source vector of four FP32 lanes, the previous destination value and a mode code. Three modes decide how the results are packed:
- Scalar mode writes only halfword 0.
- Lower-narrow mode fills the low 64 bits and clears the high 64 bits.
- Upper-narrow mode fills the high 64 bits and keeps the low 64 bits of the previous destination.

Requests use a valid/ready handshake. The result is registered and holds under back-pressure.

Top module: `bfn_narrow_conv`

## Requirements
- R1: Each FP32 lane that is finite is converted as follows. Take bits [31:16] and add one when bit 15 is set and either some bit of [14:0] is set or bit 16 is set. This is round to nearest, ties to even.
- R2: A NaN input (exponent [30:23] all ones, mantissa [22:0] nonzero) gives bits [31:16] with result bit 6 forced to one. This holds even when all mantissa bits above bit 16 are zero.
- R3: Infinities and positive or negative zero produce bits [31:16] unchanged.
- R4: A rounding carry out of the mantissa increments the exponent. A value that rounds beyond the largest finite magnitude becomes infinity of the same sign (0x7F80 or 0xFF80).
- R5: Mode code 0 (scalar) puts the converted source lane 0 (bits [31:0]) into result bits [15:0] and clears result bits [127:16].
- R6: Mode code 1 (lower-narrow) puts converted source lane i (bits [32i+31:32i]) into result bits [16i+15:16i] for i = 0..3 and clears result bits [127:64].
- R7: Mode code 2 (upper-narrow) puts converted source lane i into result bits [16i+79:16i+64] for i = 0..3. Result bits [63:0] equal bits [63:0] of the previous destination input.
- R8: Mode code 3 behaves exactly like scalar mode.
- R9: A request accepted at a clock edge (in_valid and in_ready both high) shows out_valid high with its result on out_data after that edge. out_valid is low after reset.
- R10: While out_valid is high and out_ready is low, in_ready is low, and out_data and out_valid hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_mode | input | 2 | 0 scalar, 1 lower-narrow, 2 upper-narrow, 3 scalar |
| in_src | input | 128 | Four FP32 source lanes |
| in_dst_prev | input | 128 | Previous destination contents |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| out_data | output | 128 | Packed BF16 result |

## Verification
The bench uses hand-picked lane values that separate the rounding cases:
- exact ties with an even and with an odd kept bit;
- values just above a tie;
- mantissa carries that reach the exponent and the largest finite magnitude;
- NaNs whose payload sits only in the discarded bits;
- both infinities and both zeros.

Random source vectors mixed with these specials are sent in every mode code, with random previous-destination contents, so that wrong packing, a lost low half or an uncleared high half shows up. A stall phase holds out_ready low to tell a registered, held result apart from one that follows the inputs.

// File: rtl/bfn_pkg.sv
package bfn_pkg;
  localparam int FP_W     = 32;
  localparam int BF_W     = 16;
  localparam int NLANE    = 4;
  localparam int VEC_W    = FP_W * NLANE;
  localparam int HALF_W   = BF_W * NLANE;
  localparam int DROP_W   = FP_W - BF_W;
  localparam int EXP_HI   = 30;
  localparam int EXP_LO   = 23;
  localparam int QUIET_BIT = 6;

  typedef enum logic [1:0] {
    MODE_SCALAR  = 2'd0,
    MODE_LOWER   = 2'd1,
    MODE_UPPER   = 2'd2,
    MODE_SCALAR2 = 2'd3
  } pack_mode_e;
endpackage

// File: rtl/bfn_lane_cvt.sv
module bfn_lane_cvt
  import bfn_pkg::*;
(
  input  logic [FP_W-1:0] fp_in,
  output logic [BF_W-1:0] bf_out
);
  logic [BF_W-1:0] kept;
  logic            lsb_bit;
  logic            rnd_bit;
  logic            sticky;
  logic            exp_max;
  logic            is_nan;

  always_comb begin
    kept    = fp_in[FP_W-1:DROP_W];
    lsb_bit = fp_in[DROP_W];
    rnd_bit = fp_in[DROP_W-1];
    sticky  = |fp_in[DROP_W-2:0];
    exp_max = &fp_in[EXP_HI:EXP_LO];
    is_nan  = exp_max && (|fp_in[EXP_LO-1:0]);
    if (is_nan) begin
      bf_out = kept | (BF_W'(1) << QUIET_BIT);
    end else if (exp_max) begin
      bf_out = kept;
    end else begin
      bf_out = kept + BF_W'(rnd_bit & (sticky | lsb_bit));
    end
  end
endmodule

// File: rtl/bfn_pack.sv
module bfn_pack
  import bfn_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic [HALF_W-1:0] conv,
  input  logic [VEC_W-1:0]  dst_prev,
  output logic [VEC_W-1:0]  packed_out
);
  always_comb begin
    packed_out = '0;
    case (pack_mode_e'(mode))
      MODE_LOWER: packed_out[HALF_W-1:0] = conv;
      MODE_UPPER: begin
        packed_out[VEC_W-1:VEC_W-HALF_W] = conv;
        packed_out[HALF_W-1:0]           = dst_prev[HALF_W-1:0];
      end
      default:    packed_out[BF_W-1:0] = conv[BF_W-1:0];
    endcase
  end
endmodule

// File: rtl/bfn_narrow_conv.sv
module bfn_narrow_conv
  import bfn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_mode,
  input  logic [VEC_W-1:0] in_src,
  input  logic [VEC_W-1:0] in_dst_prev,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_ok;
  logic [HALF_W-1:0] conv;
  logic [VEC_W-1:0]  packed_res;
  logic              accept;
  logic              vld_d, vld_q;
  logic              data_en;
  logic [VEC_W-1:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    bfn_lane_cvt u_cvt (
      .fp_in  (in_src[g*FP_W +: FP_W]),
      .bf_out (conv[g*BF_W +: BF_W])
    );
  end

  bfn_pack u_pack (
    .mode       (in_mode),
    .conv       (conv),
    .dst_prev   (in_dst_prev),
    .packed_out (packed_res)
  );

  assign in_ready = rst_ok && (!vld_q || out_ready);
  assign accept   = in_valid && in_ready;

  always_comb begin
    data_en = accept;
    vld_d   = vld_q;
    if (accept)         vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_q[1]) begin
    if (!rst_sync_q[1]) vld_q <= 1'b0;
    else                vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= packed_res;
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/bfn_narrow_conv_chk.sv
module bfn_narrow_conv_chk
  import bfn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_mode,
  input logic [VEC_W-1:0] in_src,
  input logic [VEC_W-1:0] in_dst_prev,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_SCALAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_mode == 2'd0)) |=> (out_data[VEC_W-1:BF_W] == '0)); // R5
  AST_CODE3_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_mode == 2'd3)) |=> (out_data[VEC_W-1:BF_W] == '0)); // R8
  AST_LOWER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_mode == 2'd1)) |=> (out_data[VEC_W-1:HALF_W] == '0)); // R6
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_mode == 2'd2)) |=> (out_data[HALF_W-1:0] == $past(in_dst_prev[HALF_W-1:0]))); // R7
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_mode == 2'd0) && (&in_src[EXP_HI:EXP_LO]) && (|in_src[EXP_LO-1:0]))
    |=> (&out_data[14:QUIET_BIT])); // R2
endmodule

bind bfn_narrow_conv bfn_narrow_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_src(in_src), .in_dst_prev(in_dst_prev),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/bfn_narrow_conv_bench.sv
module bfn_narrow_conv_bench;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   in_mode;
  logic [127:0] in_src;
  logic [127:0] in_dst_prev;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  int unsigned cycles = 0;
  bit          done   = 0;

  bfn_narrow_conv u_bfn_narrow_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_src(in_src), .in_dst_prev(in_dst_prev),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] ref_cvt(input logic [31:0] f);
    logic [7:0]  e;
    logic [22:0] m;
    logic [15:0] low;
    e   = f[30:23];
    m   = f[22:0];
    low = f[15:0];
    if (e == 8'd255 && m != 0) return {f[31:23], 1'b1, f[21:16]};   // R2
    if (e == 8'd255) return f[31:16];                                 // R3
    if (low > 16'h8000 || (low == 16'h8000 && f[16])) return f[31:16] + 16'd1; // R1 R4
    return f[31:16];
  endfunction

  function automatic logic [127:0] ref_pack(input logic [1:0] md,
                                            input logic [127:0] s,
                                            input logic [127:0] p);
    logic [63:0] c;
    for (int i = 0; i < 4; i++) c[16*i +: 16] = ref_cvt(s[32*i +: 32]);
    case (md)
      2'd1:    return {64'd0, c};                 // R6
      2'd2:    return {c, p[63:0]};               // R7
      default: return {112'd0, c[15:0]};          // R5 R8
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input string req, input logic [1:0] md,
                       input logic [127:0] s, input logic [127:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_mode = md; in_src = s; in_dst_prev = p; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R9 valid"}, {127'd0, out_valid}, 128'd1);
    check(req, out_data, ref_pack(md, s, p));
  endtask

  function automatic logic [31:0] pick_lane();
    logic [31:0] sp[10] = '{32'h3F808000, 32'h3F818000, 32'h3F808001, 32'h7F7FFFFF,
                            32'hFF800000, 32'h80000000, 32'h7F800001, 32'hFFA00000,
                            32'h3F7FFFFF, 32'h00000000};
    if ($urandom_range(3) == 0) return sp[$urandom_range(9)];
    return $urandom;
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_mode = 2'd0; in_src = '0;
    in_dst_prev = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset out_valid", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 in_ready after reset", {127'd0, in_ready}, 128'd1);

    // directed rounding and specials, one lane at a time in scalar mode
    do_op("R1 tie even",       2'd0, {96'd0, 32'h3F808000}, '1);
    do_op("R1 tie odd",        2'd0, {96'd0, 32'h3F818000}, '1);
    do_op("R1 above tie",      2'd0, {96'd0, 32'h3F808001}, '1);
    do_op("R4 carry exponent", 2'd0, {96'd0, 32'h3F7FFFFF}, '1);
    do_op("R4 overflow inf",   2'd0, {96'd0, 32'h7F7FFFFF}, '1);
    do_op("R4 neg overflow",   2'd0, {96'd0, 32'hFF7FFFFF}, '1);
    do_op("R3 neg inf",        2'd0, {96'd0, 32'hFF800000}, '1);
    do_op("R3 neg zero",       2'd0, {96'd0, 32'h80000000}, '1);
    do_op("R2 nan low payload",2'd0, {96'd0, 32'h7F800001}, '1);
    do_op("R2 signalling nan", 2'd0, {96'd0, 32'hFFA00000}, '1);
    do_op("R5 scalar upper lanes", 2'd0, {32'h3F800000, 32'h40000000, 32'h40400000, 32'h3F808000}, '1);
    do_op("R6 lower narrow",   2'd1, {32'h7F7FFFFF, 32'h80000000, 32'h3F818000, 32'h7F800001}, '1);
    do_op("R7 upper narrow",   2'd2, {32'h3F808001, 32'hFF800000, 32'h3F7FFFFF, 32'h00000000},
          128'h0123456789ABCDEF_FEDCBA9876543210);
    do_op("R8 code3 scalar",   2'd3, {32'h3F800000, 32'h40000000, 32'h40400000, 32'h3F818000}, '1);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [127:0] s;
      logic [1:0]   md;
      for (int i = 0; i < 4; i++) s[32*i +: 32] = pick_lane();
      md = 2'($urandom_range(3));
      do_op(md == 2'd1 ? "R6 R1 random" : md == 2'd2 ? "R7 R1 random" :
            md == 2'd3 ? "R8 random" : "R5 random",
            md, s, {$urandom, $urandom, $urandom, $urandom});
    end

    // stall: result must hold and input must be blocked
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'd1; in_src = {32'h3F808000, 32'h12345678, 32'hC0490FDB, 32'h7FC00000};
    in_dst_prev = '0; out_ready = 1'b0;
    held = ref_pack(2'd1, in_src, '0);
    @(negedge clk);
    in_src = {4{32'h40490FDB}}; in_mode = 2'd0;
    for (int j = 0; j < 3; j++) begin
      check("R10 stall in_ready", {127'd0, in_ready}, 128'd0);
      check("R10 stall data", out_data, held);
      check("R10 stall valid", {127'd0, out_valid}, 128'd1);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", {127'd0, out_valid}, 128'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule